// File: doc/BRIEF.md
# PLL Frequency Lock Detector

This block judges whether a phase-locked loop has settled on its programmed frequency. It counts edges of the divided feedback clock, which arrive as single-cycle pulses already synchronized into the local clock domain. It takes the count over a measurement window that a single-cycle tick from the reference domain marks out, and compares it with an expected count supplied by configuration. The absolute difference between the two is tested against two tolerances derived from the expected count. A narrow tolerance must hold for several windows in a row before lock is declared. A wider one must be broken before lock is withdrawn. This gap gives the flag hysteresis, so small jitter near the threshold does not make it toggle.

The live lock flag is registered, so any sample taken while a window is being judged sees the state from before that judgement. A second output qualifies the release of power-on reset. It rises together with the first lock and then holds until the block is reset. When the chip runs from an external clock with the loop bypassed, the lock flag is forced low and the reset qualifier is granted at once.

Top module: `pll_lock_detect`

## Requirements
- R1: The count for a window is the number of cycles with `fb_edge` high after the previous `win_tick`, up to and including the cycle of the current `win_tick`. It saturates at 2^CNT_W-1 and restarts from zero after each tick.
- R2: The first `win_tick` after reset only opens a measurement window. That partial window is never judged, so `locked` stays 0 at least until the second tick has been evaluated.
- R3: While unlocked, a window is within acquire tolerance when |count - exp_count| <= floor(exp_count / 2^ACQ_SHIFT) (ACQ_SHIFT = 7, so exp_count/128). `locked` sets after ACQ_WINS (2) consecutive judged windows within that tolerance. Any judged window outside it restarts the run.
- R4: While locked, `locked` clears after a judged window with |count - exp_count| > floor(exp_count / 2^LOSS_SHIFT) (LOSS_SHIFT = 6, so exp_count/64). Windows inside that wider tolerance keep it set.
- R5: While `ext_clk_mode` is 1, `locked` is 0 and the acquire run is cleared.
- R6: `por_release` is 0 after reset. It goes to 1 in the same cycle that `locked` first goes to 1 and stays 1 until reset, even if lock is later lost. It is 1 whenever `ext_clk_mode` is 1.
- R7: A window ending with `win_tick` high in cycle T changes `locked` and `por_release` only at the second rising edge after T begins. In cycle T and in cycle T+1 the outputs still show the earlier state.
- R8: An active-low `rst_n` clears `locked`, `por_release` (outside external clock mode), the acquire run, the counter and the arming state at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Local clock in which tick and edge pulses are sampled |
| rst_n | input | 1 | Asynchronous active-low reset |
| win_tick | input | 1 | Single-cycle pulse closing one window and opening the next |
| fb_edge | input | 1 | Single-cycle pulse per synchronized feedback edge |
| exp_count | input | CNT_W | Expected edge count per window |
| ext_clk_mode | input | 1 | 1 when the external clock bypasses the loop |
| locked | output | 1 | Live lock flag |
| por_release | output | 1 | Qualifier allowing power-on reset to release |

## Verification
The bench builds the block with CNT_W = 10 and the default shifts. With an expected count of 256, the acquire tolerance is 2 edges and the loss tolerance is 4, so a sweep of offsets from -8 to +8 crosses both thresholds on each side, one edge at a time. An expected count of 1020 lets window counts run past the 10-bit ceiling, which separates saturation from wrap-around. Runs with an edge in the tick cycle, an interrupted acquire run and external clock mode cover the remaining orderings.

// File: rtl/pll_lock_pkg.sv
package pll_lock_pkg;

   // Result of judging one captured window against the two tolerances.
   typedef struct packed {
      logic in_acq;   // inside the narrow (acquire) tolerance
      logic in_hold;  // inside the wide (loss) tolerance
   } tol_res_t;

endpackage

// File: rtl/lock_win_counter.sv
module lock_win_counter #(
   parameter int CNT_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             win_tick,
   input  logic             fb_edge,
   output logic [CNT_W-1:0] cap_count,
   output logic             cap_vld
);
   localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

   logic [CNT_W-1:0] run_cnt;
   logic [CNT_W-1:0] run_nxt;
   logic             armed;

   // Saturating increment; the edge in the tick cycle belongs to the closing window.
   always_comb begin
      run_nxt = run_cnt;
      if (fb_edge && (run_cnt != CMAX)) run_nxt = run_cnt + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_cnt   <= '0;
         cap_count <= '0;
         cap_vld   <= 1'b0;
         armed     <= 1'b0;
      end else begin
         cap_vld <= 1'b0;
         if (win_tick) begin
            cap_count <= run_nxt;
            cap_vld   <= armed;
            armed     <= 1'b1;
            run_cnt   <= '0;
         end else begin
            run_cnt <= run_nxt;
         end
      end
   end

   // R1: a full counter never wraps on a further edge
   a_r1_count_saturates: assert property (@(posedge clk) disable iff (!rst_n)
      (run_cnt == CMAX && fb_edge && !win_tick) |=> (run_cnt == CMAX));

   // R2: a window is judged only after the counter was armed by an earlier tick
   a_r2_first_tick_unjudged: assert property (@(posedge clk) disable iff (!rst_n)
      cap_vld |-> $past(armed));

endmodule

// File: rtl/lock_tol_cmp.sv
module lock_tol_cmp
   import pll_lock_pkg::*;
#(
   parameter int CNT_W      = 12,
   parameter int ACQ_SHIFT  = 7,
   parameter int LOSS_SHIFT = 6
) (
   input  logic [CNT_W-1:0] cap_count,
   input  logic [CNT_W-1:0] exp_count,
   output tol_res_t         res
);
   logic [CNT_W-1:0] abs_diff;
   logic [CNT_W-1:0] acq_tol;
   logic [CNT_W-1:0] loss_tol;

   always_comb begin
      abs_diff = (cap_count >= exp_count) ? (cap_count - exp_count)
                                          : (exp_count - cap_count);
      acq_tol     = exp_count >> ACQ_SHIFT;
      loss_tol    = exp_count >> LOSS_SHIFT;
      res.in_acq  = (abs_diff <= acq_tol);
      res.in_hold = (abs_diff <= loss_tol);
   end

   // R3/R4: the narrow band is always contained in the wide band
   always_comb begin
      a_r4_bands_nested: assert (!res.in_acq || res.in_hold);
   end

endmodule

// File: rtl/lock_hyst_fsm.sv
module lock_hyst_fsm
   import pll_lock_pkg::*;
#(
   parameter int ACQ_WINS = 2
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     eval_vld,
   input  tol_res_t res,
   input  logic     ext_clk_mode,
   output logic     locked,
   output logic     por_release
);
   localparam int SW = (ACQ_WINS > 1) ? $clog2(ACQ_WINS) : 1;

   logic acq_done;
   logic por_q;

   generate
      if (ACQ_WINS == 1) begin : g_single
         assign acq_done = res.in_acq;
      end else begin : g_streak
         logic [SW-1:0] streak;
         localparam logic [SW-1:0] LAST = SW'(ACQ_WINS - 1);

         assign acq_done = res.in_acq && (streak == LAST);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               streak <= '0;
            end else if (ext_clk_mode) begin
               streak <= '0;
            end else if (eval_vld) begin
               if (locked || !res.in_acq || streak == LAST) streak <= '0;
               else                                         streak <= streak + 1'b1;
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         locked <= 1'b0;
         por_q  <= 1'b0;
      end else begin
         if (locked) por_q <= 1'b1;
         if (ext_clk_mode)                   locked <= 1'b0;
         else if (eval_vld && locked)        locked <= res.in_hold;
         else if (eval_vld && acq_done)      locked <= 1'b1;
      end
   end

   assign por_release = por_q | locked | ext_clk_mode;

   // R5: external clock mode keeps the flag low
   a_r5_ext_no_lock: assert property (@(posedge clk) disable iff (!rst_n)
      ext_clk_mode |=> !locked);

   // R3: lock is only gained as the result of a judged window inside the narrow band
   a_r3_gain_on_eval: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(locked) |-> $past(eval_vld && res.in_acq));

   // R4: outside external mode, lock is only lost on a judged window outside the wide band
   a_r4_loss_on_eval: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(locked) && !$past(ext_clk_mode)) |-> $past(eval_vld && !res.in_hold));

   // R6: once granted, the reset qualifier holds
   a_r6_por_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      por_release && !ext_clk_mode |=> (por_release || ext_clk_mode) && por_q);

endmodule

// File: rtl/pll_lock_detect.sv
module pll_lock_detect
   import pll_lock_pkg::*;
#(
   parameter int CNT_W      = 12,
   parameter int ACQ_SHIFT  = 7,
   parameter int LOSS_SHIFT = 6,
   parameter int ACQ_WINS   = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             win_tick,
   input  logic             fb_edge,
   input  logic [CNT_W-1:0] exp_count,
   input  logic             ext_clk_mode,
   output logic             locked,
   output logic             por_release
);
   // Elaboration-time parameter checks
   generate
      if (CNT_W < 2) begin : g_bad_width
         $error("CNT_W must be at least 2");
      end
      if (LOSS_SHIFT >= ACQ_SHIFT) begin : g_bad_band
         $error("loss tolerance must be wider than acquire tolerance");
      end
      if (ACQ_SHIFT >= CNT_W) begin : g_bad_shift
         $error("ACQ_SHIFT must be below CNT_W");
      end
      if (ACQ_WINS < 1) begin : g_bad_wins
         $error("ACQ_WINS must be at least 1");
      end
   endgenerate

   logic [CNT_W-1:0] cap_count;
   logic             cap_vld;
   tol_res_t         res;

   lock_win_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .win_tick  (win_tick),
      .fb_edge   (fb_edge),
      .cap_count (cap_count),
      .cap_vld   (cap_vld)
   );

   lock_tol_cmp #(
      .CNT_W      (CNT_W),
      .ACQ_SHIFT  (ACQ_SHIFT),
      .LOSS_SHIFT (LOSS_SHIFT)
   ) u_cmp (
      .cap_count (cap_count),
      .exp_count (exp_count),
      .res       (res)
   );

   lock_hyst_fsm #(.ACQ_WINS(ACQ_WINS)) u_fsm (
      .clk          (clk),
      .rst_n        (rst_n),
      .eval_vld     (cap_vld),
      .res          (res),
      .ext_clk_mode (ext_clk_mode),
      .locked       (locked),
      .por_release  (por_release)
   );

   // R7: the flag never moves in the cycle after a tick
   a_r7_no_change_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
      $past(win_tick) |-> $stable(locked));

endmodule

// File: tb/sim_pll_lock_detect.sv
module sim_pll_lock_detect;
   localparam int CNT_W = 10;
   localparam int CMAX  = (1 << CNT_W) - 1;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             win_tick = 1'b0;
   logic             fb_edge = 1'b0;
   logic [CNT_W-1:0] exp_count = 10'd256;
   logic             ext_clk_mode = 1'b0;
   logic             locked;
   logic             por_release;

   int  n_chk = 0;
   int  n_fail = 0;
   bit  done = 1'b0;

   // reference model state
   bit  m_locked, m_por, m_armed;
   int  m_streak;

   always #10 clk = ~clk;

   pll_lock_detect #(.CNT_W(CNT_W)) u0 (
      .clk(clk), .rst_n(rst_n), .win_tick(win_tick), .fb_edge(fb_edge),
      .exp_count(exp_count), .ext_clk_mode(ext_clk_mode),
      .locked(locked), .por_release(por_release)
   );

   task automatic chk(input string req, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; win_tick = 1'b0; fb_edge = 1'b0;
      #1;
      chk("R8 locked async", locked, 1'b0);
      chk("R8 por async", por_release, ext_clk_mode);
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      m_locked = 0; m_por = 0; m_armed = 0; m_streak = 0;
      @(negedge clk);
      chk("R8 locked reset", locked, 1'b0);
      chk("R6 por reset", por_release, ext_clk_mode);
   endtask

   // n edges, optionally with the last one in the tick cycle
   task automatic window(input int n, input bit tick_edge, input string req);
      int   pre;
      int   cnt;
      int   ex;
      int   diff;
      bit   old_l, old_p;
      pre = tick_edge ? n - 1 : n;
      for (int i = 0; i < pre; i++) begin
         @(negedge clk) fb_edge = 1'b1;
      end
      @(negedge clk) fb_edge = 1'b0;
      @(negedge clk) win_tick = 1'b1; fb_edge = tick_edge;
      old_l = m_locked;
      old_p = m_por | ext_clk_mode;
      @(negedge clk) win_tick = 1'b0; fb_edge = 1'b0;
      chk("R7 locked held", locked, old_l);
      chk("R7 por held", por_release, old_p);
      // model
      cnt = (n > CMAX) ? CMAX : n;
      ex  = int'(exp_count);
      diff = (cnt > ex) ? cnt - ex : ex - cnt;
      if (!m_armed) begin
         m_armed = 1;
      end else if (ext_clk_mode) begin
         m_locked = 0; m_streak = 0;
      end else if (m_locked) begin
         if (diff > (ex >> 6)) m_locked = 0;
      end else if (diff <= (ex >> 7)) begin
         m_streak++;
         if (m_streak == 2) begin m_locked = 1; m_streak = 0; end
      end else begin
         m_streak = 0;
      end
      if (m_locked) m_por = 1;
      if (ext_clk_mode) begin m_locked = 0; m_streak = 0; end
      @(negedge clk);
      chk(req, locked, m_locked);
      chk({req, " por R6"}, por_release, m_por | ext_clk_mode);
   endtask

   initial begin
      // R8/R6 reset state
      do_reset();

      // R3 acquire sweep around 256 (acquire tolerance 2)
      exp_count = 10'd256;
      for (int off = -6; off <= 6; off++) begin
         do_reset();
         window(256, 0, "R2 first window");
         window(256 + off, 0, "R3 acquire 1");
         window(256 + off, 0, "R3 acquire 2");
      end

      // R4 loss sweep (loss tolerance 4)
      for (int off = -8; off <= 8; off++) begin
         do_reset();
         window(256, 0, "R2 first window");
         window(256, 0, "R3 lock");
         window(256, 0, "R3 lock");
         window(256 + off, 0, "R4 loss");
         window(256, 0, "R6 after loss");
      end

      // R3 broken run restarts, R4 hysteresis band keeps lock
      do_reset();
      window(256, 0, "R2 first window");
      window(256, 0, "R3 run 1");
      window(259, 0, "R3 run broken");
      window(256, 0, "R3 run restart");
      window(256, 0, "R3 run complete");
      window(259, 0, "R4 inside wide band");
      window(252, 0, "R4 inside wide band low");

      // R1 edge in tick cycle counted, exp 200 (tolerance 1)
      exp_count = 10'd200;
      do_reset();
      window(200, 1, "R1 tick edge");
      window(201, 1, "R1 tick edge");
      window(199, 1, "R1 tick edge");
      window(202, 1, "R1 tick edge");

      // R1 saturation at 1023
      exp_count = 10'd1020;
      do_reset();
      window(1030, 0, "R1 saturate");
      window(1030, 0, "R1 saturate");
      window(1040, 0, "R1 saturate");
      window(900, 0, "R1 low count");

      // R5 external clock mode
      exp_count = 10'd256;
      ext_clk_mode = 1'b1;
      do_reset();
      window(256, 0, "R5 ext");
      window(256, 0, "R5 ext");
      window(256, 0, "R5 ext");
      ext_clk_mode = 1'b0;

      // R8 reset while locked
      do_reset();
      window(256, 0, "R2 first window");
      window(256, 0, "R3 lock");
      window(256, 0, "R3 lock");
      do_reset();
      window(256, 0, "R2 after reset");
      window(256, 0, "R3 relock 1");

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

endmodule